// File: doc/BRIEF.md
# Synthetic Converter Register Bank

This block is a word-addressed register file. It looks like the control and result registers of an analog-to-digital converter, but no analog front end sits behind it. A host reaches it through a 32-bit slave port with separate read and write strobes. The port covers a 256-byte window. Most locations are plain storage. The status word can only be cleared. One control word hides its top nibble on reads. The injected-offset words keep only 12 bits. The injected-data words read back with their offset taken off.

The result-data location does the real work. When the converter-enable and software-start bits are both set, a read of that location does three things:

- It advances an internal sample counter by a fixed step.
- It cuts the counter down to the resolution chosen in control word 1.
- It returns the sample either right-justified or left-justified, as control word 2 selects.

The start bit then clears itself. As a result, each start request yields exactly one fresh sample. Software and system models use the block where a plausible, changing converter reading is enough.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `synth_adc_regs`

## Requirements
- R1: After reset every location reads zero, except the high-threshold word at offset 0x24, which reads 0x00000FFF.
- R2: A write to the status word at 0x00 can only clear bits: the new value is the old value ANDed with bits 5:0 of the write data, so the status word reads zero from reset onward.
- R3: A read of control word 2 (offset 0x08) returns its stored value with bits 31:28 forced to zero.
- R4: A read of the result word (0x4C) returns zero and changes no state unless control word 2 has both bit 0 (enable) and bit 30 (start) set.
- R5: With both bits set, a result read clears bit 30 and replaces the stored sample with (sample + 7) masked by control word 1 bits 25:24. The codes are 0 for 12 bits, 1 for 10 bits, 2 for 8 bits and 3 for 6 bits. The masked sum wraps within that width.
- R6: When bit 11 of control word 2 is set, the returned sample is the new masked value shifted left by one and ANDed with 0xFFF0; otherwise it is the masked value itself.
- R7: The four injected-offset words (0x14, 0x18, 0x1C, 0x20) keep only bits 11:0 of write data; the upper bits read zero.
- R8: A read of injected-data word n (0x3C, 0x40, 0x44, 0x48) returns stored data n minus offset n, modulo 2^32.
- R9: Offsets 0x50 and above, and any address with bits 1:0 non-zero, read as zero and ignore writes; the result word ignores writes as well.
- R10: Control word 1 (0x04), the sample-time words (0x0C, 0x10), the thresholds (0x24, 0x28) and the sequence words (0x2C, 0x30, 0x34, 0x38) store and return all 32 bits.
- R11: Read data is registered: it changes only on the clock edge that accepts a read strobe, and it then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. The same rule is also checked at the port. The stimulus meets it by driving every access through a task that asserts exactly one strobe for one cycle and then returns to idle. The random mix forces control-word-2 writes to set the enable and start bits often, so that result reads advance the sample under every resolution code and both alignments. Directed runs push the 12-bit sample past its wrap point and touch misaligned and out-of-window addresses.

// File: rtl/synth_adc_pkg.sv
`timescale 1ns/1ps
package synth_adc_pkg;
  // byte offsets inside the window
  localparam int OFF_STAT  = 8'h00;
  localparam int OFF_CTL1  = 8'h04;
  localparam int OFF_CTL2  = 8'h08;
  localparam int OFF_SMP1  = 8'h0C;
  localparam int OFF_SMP2  = 8'h10;
  localparam int OFF_JOFR0 = 8'h14;
  localparam int OFF_HTHR  = 8'h24;
  localparam int OFF_LTHR  = 8'h28;
  localparam int OFF_SEQ1  = 8'h2C;
  localparam int OFF_SEQ2  = 8'h30;
  localparam int OFF_SEQ3  = 8'h34;
  localparam int OFF_JSEQ  = 8'h38;
  localparam int OFF_JDAT0 = 8'h3C;
  localparam int OFF_RES   = 8'h4C;

  // control bit positions
  localparam int CTL2_ON    = 0;
  localparam int CTL2_ALIGN = 11;
  localparam int CTL2_START = 30;
  localparam int CTL1_RES_LO = 24;

  localparam int STAT_W = 6;
  localparam logic [31:0] HTHR_RST = 32'h0000_0FFF;
  localparam logic [31:0] CTL2_RD_MASK = 32'h0FFF_FFFF;
  localparam logic [31:0] ALIGN_MASK = 32'h0000_FFF0;

  function automatic logic [31:0] res_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_0FFF;
      2'd1:    return 32'h0000_03FF;
      2'd2:    return 32'h0000_00FF;
      default: return 32'h0000_003F;
    endcase
  endfunction
endpackage

// File: rtl/sadc_sample_gen.sv
`timescale 1ns/1ps
module sadc_sample_gen
  import synth_adc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [1:0]        res,
  input  logic              align,
  output logic [DATA_W-1:0] sample
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] nxt;

  assign nxt = (cnt_q + DATA_W'(STEP)) & DATA_W'(res_mask(res));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (fire) cnt_q <= nxt;
  end

  assign sample = align ? ((nxt << 1) & DATA_W'(ALIGN_MASK)) : nxt;
endmodule

// File: rtl/sadc_inj_bank.sv
`timescale 1ns/1ps
module sadc_inj_bank
  import synth_adc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_INJ  = 4,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              hit
);
  logic [OFS_W-1:0]  ofs_q [N_INJ];
  logic [DATA_W-1:0] dat_q [N_INJ];
  logic [N_INJ-1:0]  ofs_hit;
  logic [N_INJ-1:0]  dat_hit;

  for (genvar g = 0; g < N_INJ; g++) begin : g_ch
    assign ofs_hit[g] = (addr == ADDR_W'(OFF_JOFR0 + 4*g));
    assign dat_hit[g] = (addr == ADDR_W'(OFF_JDAT0 + 4*g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ofs_q[g] <= '0;
        dat_q[g] <= '0;
      end else if (wr) begin
        if (ofs_hit[g]) ofs_q[g] <= wdata[OFS_W-1:0];
        if (dat_hit[g]) dat_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_INJ; i++) begin
      if (ofs_hit[i]) rd_val = DATA_W'(ofs_q[i]);
      if (dat_hit[i]) rd_val = dat_q[i] - DATA_W'(ofs_q[i]);
    end
  end

  assign hit = |{ofs_hit, dat_hit};
endmodule

// File: rtl/synth_adc_regs.sv
`timescale 1ns/1ps
module synth_adc_regs
  import synth_adc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_INJ  = 4,
  parameter int OFS_W  = 12,
  parameter int STEP   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int N_PLAIN = 9;
  localparam int PLAIN_OFF [N_PLAIN] = '{OFF_CTL1, OFF_SMP1, OFF_SMP2, OFF_HTHR,
                                         OFF_LTHR, OFF_SEQ1, OFF_SEQ2, OFF_SEQ3,
                                         OFF_JSEQ};

  // plain storage words
  logic [DATA_W-1:0]  plain_q [N_PLAIN];
  logic [N_PLAIN-1:0] plain_hit;
  logic [DATA_W-1:0]  plain_rd;

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    localparam logic [DATA_W-1:0] RST_V =
      (PLAIN_OFF[g] == OFF_HTHR) ? DATA_W'(HTHR_RST) : '0;
    assign plain_hit[g] = (bus_addr == ADDR_W'(PLAIN_OFF[g]));
    always_ff @(posedge clk) begin
      if (rst)                        plain_q[g] <= RST_V;
      else if (bus_wr && plain_hit[g]) plain_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    plain_rd = '0;
    for (int i = 0; i < N_PLAIN; i++)
      if (plain_hit[i]) plain_rd = plain_q[i];
  end

  // decode of the special words
  logic stat_hit, ctl2_hit, res_hit;
  assign stat_hit = (bus_addr == ADDR_W'(OFF_STAT));
  assign ctl2_hit = (bus_addr == ADDR_W'(OFF_CTL2));
  assign res_hit  = (bus_addr == ADDR_W'(OFF_RES));

  // status: clear-only
  logic [STAT_W-1:0] stat_q;
  always_ff @(posedge clk) begin
    if (rst)                    stat_q <= '0;
    else if (bus_wr && stat_hit) stat_q <= stat_q & bus_wdata[STAT_W-1:0];
  end

  // control word 2 with self-clearing start bit
  logic [DATA_W-1:0] ctl2_q;
  logic              fire;
  logic [1:0]        res_code;

  assign fire     = bus_rd && res_hit && ctl2_q[CTL2_ON] && ctl2_q[CTL2_START];
  assign res_code = plain_q[0][CTL1_RES_LO+1:CTL1_RES_LO];

  always_ff @(posedge clk) begin
    if (rst)                    ctl2_q <= '0;
    else if (bus_wr && ctl2_hit) ctl2_q <= bus_wdata;
    else if (fire)              ctl2_q[CTL2_START] <= 1'b0;
  end

  // sample generator
  logic [DATA_W-1:0] sample;
  sadc_sample_gen #(.DATA_W(DATA_W), .STEP(STEP)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .res    (res_code),
    .align  (ctl2_q[CTL2_ALIGN]),
    .sample (sample)
  );

  // injected offset / data words
  logic [DATA_W-1:0] inj_rd;
  logic              inj_hit;
  sadc_inj_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_INJ(N_INJ), .OFS_W(OFS_W)) u_inj (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rd_val (inj_rd),
    .hit    (inj_hit)
  );

  // read mux and registered read data
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    if (stat_hit)      rd_mux = DATA_W'(stat_q);
    else if (ctl2_hit) rd_mux = ctl2_q & DATA_W'(CTL2_RD_MASK);
    else if (res_hit)  rd_mux = fire ? sample : '0;
    else if (inj_hit)  rd_mux = inj_rd;
    else               rd_mux = plain_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sadc_chk.sv
`timescale 1ns/1ps
module sadc_chk
  import synth_adc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctl2_q,
  input logic [1:0]        res_code
);
  logic rd_res, on_go;
  assign rd_res = bus_rd && (bus_addr == ADDR_W'(OFF_RES));
  assign on_go  = ctl2_q[CTL2_ON] && ctl2_q[CTL2_START];

  AST_RDATA_RESET: assert property (@(posedge clk) rst |=> bus_rdata == '0); // R1
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(OFF_STAT) |=> bus_rdata == '0); // R2
  AST_CTL2_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(OFF_CTL2) |=> bus_rdata[31:28] == 4'h0); // R3
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_res && !on_go |=> bus_rdata == '0 && $stable(ctl2_q)); // R4
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rd_res && on_go |=> !ctl2_q[CTL2_START]); // R5
  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_res && on_go && !ctl2_q[CTL2_ALIGN]
    |=> (bus_rdata & ~DATA_W'(res_mask($past(res_code)))) == '0); // R5
  AST_ALIGN_SHAPE: assert property (@(posedge clk) disable iff (rst)
    rd_res && on_go && ctl2_q[CTL2_ALIGN]
    |=> bus_rdata[3:0] == 4'h0 && bus_rdata[DATA_W-1:16] == '0); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R11
endmodule

bind synth_adc_regs sadc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ctl2_q    (ctl2_q),
  .res_code  (res_code)
);

// File: tb/synth_adc_regs_bench.sv
`timescale 1ns/1ps
module synth_adc_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  synth_adc_regs u_synth_adc_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // reference model state
  logic [31:0] m_reg [64];
  logic [31:0] m_ofs [4];
  logic [31:0] m_dat [4];
  logic [31:0] m_ctl2, m_res;
  logic [5:0]  m_stat;

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    m_reg[8'h24 >> 2] = 32'h0000_0FFF;
    for (int i = 0; i < 4; i++) begin m_ofs[i] = '0; m_dat[i] = '0; end
    m_ctl2 = '0; m_res = '0; m_stat = '0;
  endtask

  function automatic logic [31:0] bits_mask(input logic [1:0] c);
    case (c)
      2'd0: return 32'hFFF;
      2'd1: return 32'h3FF;
      2'd2: return 32'hFF;
      default: return 32'h3F;
    endcase
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a < 8'h50);
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (!mapped(a)) return;
    if (a == 8'h00) m_stat = m_stat & d[5:0];
    else if (a == 8'h08) m_ctl2 = d;
    else if (a >= 8'h14 && a <= 8'h20) m_ofs[(a - 8'h14) >> 2] = d & 32'hFFF;
    else if (a >= 8'h3C && a <= 8'h48) m_dat[(a - 8'h3C) >> 2] = d;
    else if (a == 8'h4C) ;
    else m_reg[a >> 2] = d;
  endtask

  task automatic model_read(input logic [7:0] a, output logic [31:0] v, output string tag);
    v = '0;
    if (!mapped(a)) begin tag = "R9"; return; end
    if (a == 8'h00) begin v = {26'b0, m_stat}; tag = "R2"; end
    else if (a == 8'h08) begin v = m_ctl2 & 32'h0FFF_FFFF; tag = "R3"; end
    else if (a >= 8'h14 && a <= 8'h20) begin v = m_ofs[(a - 8'h14) >> 2]; tag = "R7"; end
    else if (a >= 8'h3C && a <= 8'h48) begin
      v = m_dat[(a - 8'h3C) >> 2] - m_ofs[(a - 8'h3C) >> 2]; tag = "R8";
    end
    else if (a == 8'h4C) begin
      if (m_ctl2[0] && m_ctl2[30]) begin
        m_ctl2[30] = 1'b0;
        m_res = (m_res + 32'd7) & bits_mask(m_reg[1][25:24]);
        v = m_ctl2[11] ? ((m_res << 1) & 32'hFFF0) : m_res;
        tag = m_ctl2[11] ? "R6" : "R5";
      end else tag = "R4";
    end
    else begin v = m_reg[a >> 2]; tag = "R10"; end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic read_check(input logic [7:0] a, input string force_tag);
    logic [31:0] act, exp;
    string tag;
    model_read(a, exp, tag);
    bus_read(a, act);
    check(force_tag == "" ? tag : force_tag, act, exp);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    void'($urandom(32'h5EED_0A0C));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values of every word in the window
    for (int i = 0; i < 20; i++) read_check(8'(i * 4), "R1");

    // R4: enable alone does not produce a sample
    bus_write(8'h08, 32'h0000_0001);
    read_check(8'h4C, "R4");
    bus_write(8'h08, 32'h4000_0000);
    read_check(8'h4C, "R4");

    // R5: first sample, then start has self-cleared
    bus_write(8'h04, 32'h0000_0000);
    bus_write(8'h08, 32'h4000_0001);
    read_check(8'h4C, "R5");
    read_check(8'h4C, "R5");
    read_check(8'h08, "R3");

    // R5 wrap in 12-bit mode
    for (int i = 0; i < 600; i++) begin
      bus_write(8'h08, 32'h4000_0001);
      read_check(8'h4C, "R5");
    end

    // R5/R6: every resolution, both alignments
    for (int r = 0; r < 4; r++) begin
      for (int al = 0; al < 2; al++) begin
        bus_write(8'h04, 32'(r) << 24);
        for (int k = 0; k < 12; k++) begin
          bus_write(8'h08, 32'h4000_0001 | (32'(al) << 11));
          read_check(8'h4C, al ? "R6" : "R5");
        end
      end
    end

    // R9: result word ignores writes, misaligned and out-of-window accesses
    bus_write(8'h4C, 32'hDEAD_BEEF);
    bus_write(8'h04, 32'h0);
    bus_write(8'h08, 32'h4000_0001);
    read_check(8'h4C, "R9");
    bus_write(8'h05, 32'hFFFF_FFFF);
    read_check(8'h04, "R9");
    read_check(8'h05, "R9");
    bus_write(8'h50, 32'h1234_5678);
    read_check(8'h50, "R9");
    read_check(8'hFC, "R9");

    // R3: top nibble hidden
    bus_write(8'h08, 32'hF000_0800);
    read_check(8'h08, "R3");

    // R7 / R8: offsets truncated, data minus offset wraps
    bus_write(8'h14, 32'hFFFF_FABC);
    read_check(8'h14, "R7");
    bus_write(8'h3C, 32'h0000_0005);
    read_check(8'h3C, "R8");

    // R2: status write cannot set bits
    bus_write(8'h00, 32'hFFFF_FFFF);
    read_check(8'h00, "R2");

    // R11: read data holds across idle cycles and writes
    bus_write(8'h2C, 32'hA5A5_1234);
    bus_read(8'h2C, held);
    repeat (4) @(negedge clk);
    check("R11", bus_rdata, held);
    bus_write(8'h2C, 32'h0);
    check("R11", bus_rdata, held);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      sel = int'($urandom % 10);
      d = $urandom;
      if (sel < 7) a = 8'(($urandom % 20) * 4);
      else if (sel == 7) a = 8'($urandom);
      else a = 8'h4C;
      if (sel == 9) begin
        d = (d & 32'h0000_0800) | 32'h4000_0001;
        bus_write(8'h08, d);
        read_check(8'h4C, "");
      end else if ($urandom % 2) begin
        if (a == 8'h08 && ($urandom % 2)) d = d | 32'h4000_0001;
        bus_write(a, d);
      end else begin
        read_check(a, "");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule